// File: doc/BRIEF.md
# Shared Multi-Queue Linked-Chunk Buffer

This block keeps several independent first-in-first-out queues, one per user, in a single data memory, so no user needs its own private buffer. Storage is handed out in chunks of sixteen consecutive entries. A link table holds, for each chunk, the chunk that follows it in the same queue. A pool of free chunk numbers supplies a queue whenever its tail chunk fills up, and gets a chunk back once that chunk has been read out completely.

Each clock cycle the block accepts up to two pushes and up to two pops. Each push or pop request names a user, and the two requests of a kind may name the same user or different users. Within a cycle the pops are handled first (port 0, then port 1) and the pushes after them (port 0, then port 1). Every result is registered: the push acknowledges, the pop acknowledges and refusal flags, the pop data, and the per-user empty and full flags.

With the default parameters the memory holds 256 words of 16 bits in 16 chunks, shared by 4 users. The chunk count must be a power of two.

Top module: `mq_shared_fifo`

## Requirements
- R1: While reset is held, and after it is released, every queue reports empty (`q_empty` all ones), no queue reports full (`q_full` all zeros), and all 16 chunks are free.
- R2: Each user's data leaves in the order it went in, whatever traffic the other users have. Two pops in one cycle to the same user return the older word on port 0.
- R3: A single user may fill the entire memory: starting from reset, exactly 256 pushes to one user are accepted and the next one is refused.
- R4: Storage is allocated a whole chunk at a time. If each of the four users holds one word and user 0 then keeps pushing, user 0 is accepted for exactly 207 more words (15 + 12×16). A user whose chunk still has room keeps accepting after that.
- R5: Two pushes, two pops, or both can be served in one cycle. `push_ack`, `pop_ack`, `pop_err`, `pop_data` and the flags appear at the clock edge that samples the request. An idle push port never acknowledges.
- R6: `q_full[u]` is 1 exactly when user u would need a new chunk (it holds no chunk, or its tail chunk is full) and no chunk is free. A push to a user whose flag is 1 gets `push_ack`=0.
- R7: A pop to an empty user gives `pop_err`=1 and `pop_ack`=0, and it leaves that queue unchanged.
- R8: When both pushes in a cycle need a new chunk and only one chunk is free, port 0 receives it and port 1 is refused.
- R9: A chunk emptied by a pop cannot be allocated in that same cycle. A push that needs it is refused that cycle and accepted in the next one.
- R10: A pop never returns a word pushed in the same cycle. A pop to a queue that is empty at the start of the cycle is refused even if a push to that queue is accepted in the same cycle.
- R11: A fully drained chunk goes back to the pool. A queue that empties partway through a chunk keeps that chunk. After the traffic of R4 has drained, user 0 is accepted for exactly 208 words (13 free chunks).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 2 | Push request, one bit per push port |
| push_user | input | 2×UID_W | Target user of each push port |
| push_data | input | 2×DATA_W | Word written by each push port |
| push_ack | output | 2 | Registered: push accepted |
| pop_valid | input | 2 | Pop request, one bit per pop port |
| pop_user | input | 2×UID_W | Source user of each pop port |
| pop_ack | output | 2 | Registered: pop served, `pop_data` is valid |
| pop_err | output | 2 | Registered: pop refused, queue was empty |
| pop_data | output | 2×DATA_W | Registered word for each pop port |
| q_empty | output | NUM_USERS | Registered per-user empty flag |
| q_full | output | NUM_USERS | Registered per-user full flag |

## Verification
All results are due one clock after the request: the rising edge that samples a push or pop also updates the acknowledges, the refusal flags, `pop_data` and the flags. The bench changes its inputs on the falling edge and reads the outputs 1 ns after the next rising edge, so each check looks at exactly the edge that served its request. The same-cycle cases are driven as single cycles with a known expected result for each port: port-order allocation of the last chunk, release of a chunk that only takes effect the next cycle, and a pop that is handled before a push to the same queue. The capacity counts (256, 207, 208) come from chunk arithmetic.

// File: rtl/mq_pkg.sv
package mq_pkg;
  // Number of push ports and of pop ports.
  localparam int unsigned MQ_PORTS = 2;

  // Index width for n items, at least one bit.
  function automatic int unsigned mq_idw(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/mq_free_pool.sv
module mq_free_pool
  import mq_pkg::*;
#(
  parameter int unsigned NUM_CHUNKS = 16,
  parameter int unsigned CH_W       = 4,
  parameter int unsigned FREE_W     = 5
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [1:0]                     take_cnt,
  input  logic [MQ_PORTS-1:0]            ret_v,
  input  logic [MQ_PORTS-1:0][CH_W-1:0]  ret_id,
  output logic [MQ_PORTS-1:0][CH_W-1:0]  take_id,
  output logic [FREE_W-1:0]              avail
);
  // Ring of free chunk numbers; pointers wrap because NUM_CHUNKS is a power of two.
  logic [CH_W-1:0] slot [NUM_CHUNKS];
  logic [CH_W-1:0] rd_ptr, wr_ptr;

  for (genvar p = 0; p < MQ_PORTS; p++) begin : g_head
    assign take_id[p] = slot[rd_ptr + CH_W'(p)];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_CHUNKS; i++) slot[i] <= CH_W'(i);
      rd_ptr <= '0;
      wr_ptr <= '0;
      avail  <= FREE_W'(NUM_CHUNKS);
    end else begin
      rd_ptr <= rd_ptr + CH_W'(take_cnt);
      if (ret_v[0]) slot[wr_ptr] <= ret_id[0];
      if (ret_v[1]) slot[wr_ptr + CH_W'(ret_v[0])] <= ret_id[1];
      wr_ptr <= wr_ptr + CH_W'(ret_v[0]) + CH_W'(ret_v[1]);
      avail  <= avail - FREE_W'(take_cnt) + FREE_W'(ret_v[0]) + FREE_W'(ret_v[1]);
    end
  end

  AST_TAKE_WITHIN_POOL: assert property (@(posedge clk) disable iff (rst)
    FREE_W'(take_cnt) <= avail); // R8
  AST_POOL_BOUND: assert property (@(posedge clk) disable iff (rst)
    avail <= FREE_W'(NUM_CHUNKS)); // R11
endmodule

// File: rtl/mq_link_table.sv
module mq_link_table
  import mq_pkg::*;
#(
  parameter int unsigned NUM_CHUNKS = 16,
  parameter int unsigned CH_W       = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [MQ_PORTS-1:0]            we,
  input  logic [MQ_PORTS-1:0][CH_W-1:0]  idx,
  input  logic [MQ_PORTS-1:0][CH_W-1:0]  val,
  output logic [CH_W-1:0]                next_of [NUM_CHUNKS]
);
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_CHUNKS; i++) next_of[i] <= '0;
    end else begin
      for (int p = 0; p < MQ_PORTS; p++)
        if (we[p]) next_of[idx[p]] <= val[p];
    end
  end
endmodule

// File: rtl/mq_data_store.sv
module mq_data_store
  import mq_pkg::*;
#(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                             clk,
  input  logic [MQ_PORTS-1:0]              wr_en,
  input  logic [MQ_PORTS-1:0][ADDR_W-1:0]  wr_addr,
  input  logic [MQ_PORTS-1:0][DATA_W-1:0]  wr_data,
  input  logic [MQ_PORTS-1:0]              rd_en,
  input  logic [MQ_PORTS-1:0][ADDR_W-1:0]  rd_addr,
  output logic [MQ_PORTS-1:0][DATA_W-1:0]  rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int p = 0; p < MQ_PORTS; p++)
      if (wr_en[p]) mem[wr_addr[p]] <= wr_data[p];
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < MQ_PORTS; p++)
      if (rd_en[p]) rd_data[p] <= mem[rd_addr[p]];
  end
endmodule

// File: rtl/mq_shared_fifo.sv
module mq_shared_fifo
  import mq_pkg::*;
#(
  parameter  int unsigned NUM_USERS = 4,
  parameter  int unsigned DATA_W    = 16,
  parameter  int unsigned DEPTH     = 256,
  parameter  int unsigned CHUNK_LEN = 16,
  localparam int unsigned UID_W     = mq_idw(NUM_USERS)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [MQ_PORTS-1:0]              push_valid,
  input  logic [MQ_PORTS-1:0][UID_W-1:0]   push_user,
  input  logic [MQ_PORTS-1:0][DATA_W-1:0]  push_data,
  output logic [MQ_PORTS-1:0]              push_ack,
  input  logic [MQ_PORTS-1:0]              pop_valid,
  input  logic [MQ_PORTS-1:0][UID_W-1:0]   pop_user,
  output logic [MQ_PORTS-1:0]              pop_ack,
  output logic [MQ_PORTS-1:0]              pop_err,
  output logic [MQ_PORTS-1:0][DATA_W-1:0]  pop_data,
  output logic [NUM_USERS-1:0]             q_empty,
  output logic [NUM_USERS-1:0]             q_full
);
  localparam int unsigned NUM_CHUNKS = DEPTH / CHUNK_LEN;
  localparam int unsigned CH_W       = mq_idw(NUM_CHUNKS);
  localparam int unsigned OFF_W      = mq_idw(CHUNK_LEN);
  localparam int unsigned ADDR_W     = CH_W + OFF_W;
  localparam int unsigned CNT_W      = $clog2(DEPTH + 1);
  localparam int unsigned FREE_W     = $clog2(NUM_CHUNKS + 1);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(CHUNK_LEN - 1);

  // Per-user pointer state.
  logic [CH_W-1:0]  h_ch_q  [NUM_USERS], h_ch_n  [NUM_USERS];
  logic [CH_W-1:0]  t_ch_q  [NUM_USERS], t_ch_n  [NUM_USERS];
  logic [OFF_W-1:0] h_off_q [NUM_USERS], h_off_n [NUM_USERS];
  logic [OFF_W-1:0] t_off_q [NUM_USERS], t_off_n [NUM_USERS];
  logic [CNT_W-1:0] cnt_q   [NUM_USERS], cnt_n   [NUM_USERS];
  logic             own_q   [NUM_USERS], own_n   [NUM_USERS];

  // Links between the control sequencer and the submodules.
  logic [1:0]                      take_cnt;
  logic [MQ_PORTS-1:0]             ret_v;
  logic [MQ_PORTS-1:0][CH_W-1:0]   ret_id;
  logic [MQ_PORTS-1:0][CH_W-1:0]   take_id;
  logic [FREE_W-1:0]               avail;
  logic [FREE_W-1:0]               free_next;
  logic [MQ_PORTS-1:0]             lk_we;
  logic [MQ_PORTS-1:0][CH_W-1:0]   lk_idx, lk_val;
  logic [CH_W-1:0]                 link_tab [NUM_CHUNKS];
  logic [MQ_PORTS-1:0]             wr_en, rd_en;
  logic [MQ_PORTS-1:0][ADDR_W-1:0] wr_addr, rd_addr;
  logic [MQ_PORTS-1:0][DATA_W-1:0] wr_data;
  logic [MQ_PORTS-1:0]             pop_ok, pop_bad, push_ok;
  logic [NUM_USERS-1:0]            empty_n, full_n;

  mq_free_pool #(.NUM_CHUNKS(NUM_CHUNKS), .CH_W(CH_W), .FREE_W(FREE_W)) u_pool (
    .clk(clk), .rst(rst), .take_cnt(take_cnt), .ret_v(ret_v), .ret_id(ret_id),
    .take_id(take_id), .avail(avail));

  mq_link_table #(.NUM_CHUNKS(NUM_CHUNKS), .CH_W(CH_W)) u_link (
    .clk(clk), .rst(rst), .we(lk_we), .idx(lk_idx), .val(lk_val), .next_of(link_tab));

  mq_data_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(pop_data));

  // Sequencer: pops in port order, then pushes in port order, each seeing the
  // state left by the one before it. Chunks freed here reach the pool next cycle.
  always_comb begin : seq
    int  u;
    logic need;
    h_ch_n  = h_ch_q;
    t_ch_n  = t_ch_q;
    h_off_n = h_off_q;
    t_off_n = t_off_q;
    cnt_n   = cnt_q;
    own_n   = own_q;
    take_cnt = '0;
    ret_v    = '0;
    ret_id   = '0;
    lk_we    = '0;
    lk_idx   = '0;
    lk_val   = '0;
    wr_en    = '0;
    wr_addr  = '0;
    wr_data  = '0;
    rd_en    = '0;
    rd_addr  = '0;
    pop_ok   = '0;
    pop_bad  = '0;
    push_ok  = '0;
    need     = 1'b0;
    u        = 0;

    for (int i = 0; i < MQ_PORTS; i++) begin
      if (pop_valid[i]) begin
        u = int'(pop_user[i]);
        if (u >= int'(NUM_USERS) || cnt_n[u] == '0) begin
          pop_bad[i] = 1'b1;
        end else begin
          pop_ok[i]  = 1'b1;
          rd_en[i]   = 1'b1;
          rd_addr[i] = {h_ch_n[u], h_off_n[u]};
          cnt_n[u]   = cnt_n[u] - 1'b1;
          if (h_off_n[u] == LAST_OFF) begin
            ret_v[i]   = 1'b1;
            ret_id[i]  = h_ch_n[u];
            h_off_n[u] = '0;
            if (cnt_n[u] == '0) own_n[u]  = 1'b0;
            else                h_ch_n[u] = link_tab[h_ch_n[u]];
          end else begin
            h_off_n[u] = h_off_n[u] + 1'b1;
          end
        end
      end
    end

    for (int j = 0; j < MQ_PORTS; j++) begin
      if (push_valid[j]) begin
        u = int'(push_user[j]);
        if (u < int'(NUM_USERS)) begin
          need = !own_n[u] || (t_off_n[u] == '0);
          if (!need) begin
            push_ok[j] = 1'b1;
          end else if (FREE_W'(take_cnt) < avail) begin
            push_ok[j] = 1'b1;
            if (own_n[u]) begin
              lk_we[j]  = 1'b1;
              lk_idx[j] = t_ch_n[u];
              lk_val[j] = take_id[take_cnt[0]];
            end else begin
              h_ch_n[u]  = take_id[take_cnt[0]];
              h_off_n[u] = '0;
              own_n[u]   = 1'b1;
            end
            t_ch_n[u]  = take_id[take_cnt[0]];
            t_off_n[u] = '0;
            take_cnt   = take_cnt + 2'd1;
          end
          if (push_ok[j]) begin
            wr_en[j]   = 1'b1;
            wr_addr[j] = {t_ch_n[u], t_off_n[u]};
            wr_data[j] = push_data[j];
            t_off_n[u] = t_off_n[u] + 1'b1;
            cnt_n[u]   = cnt_n[u] + 1'b1;
          end
        end
      end
    end

    free_next = avail - FREE_W'(take_cnt) + FREE_W'(ret_v[0]) + FREE_W'(ret_v[1]);
    for (int k = 0; k < NUM_USERS; k++) begin
      empty_n[k] = (cnt_n[k] == '0);
      full_n[k]  = (!own_n[k] || t_off_n[k] == '0) && (free_next == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_USERS; k++) begin
        h_ch_q[k]  <= '0;
        t_ch_q[k]  <= '0;
        h_off_q[k] <= '0;
        t_off_q[k] <= '0;
        cnt_q[k]   <= '0;
        own_q[k]   <= 1'b0;
      end
      q_empty  <= '1;
      q_full   <= '0;
      push_ack <= '0;
      pop_ack  <= '0;
      pop_err  <= '0;
    end else begin
      h_ch_q   <= h_ch_n;
      t_ch_q   <= t_ch_n;
      h_off_q  <= h_off_n;
      t_off_q  <= t_off_n;
      cnt_q    <= cnt_n;
      own_q    <= own_n;
      q_empty  <= empty_n;
      q_full   <= full_n;
      push_ack <= push_ok;
      pop_ack  <= pop_ok;
      pop_err  <= pop_bad;
    end
  end

  for (genvar p = 0; p < MQ_PORTS; p++) begin : g_chk
    AST_EMPTY_POP_FLAGGED: assert property (@(posedge clk) disable iff (rst)
      pop_valid[p] && int'(pop_user[p]) < int'(NUM_USERS) && q_empty[pop_user[p]]
      |=> pop_err[p] && !pop_ack[p]); // R7
    AST_FULL_REFUSED: assert property (@(posedge clk) disable iff (rst)
      push_valid[p] && int'(push_user[p]) < int'(NUM_USERS) && q_full[push_user[p]]
      |=> !push_ack[p]); // R6
    AST_IDLE_NO_ACK: assert property (@(posedge clk) disable iff (rst)
      !push_valid[p] |=> !push_ack[p]); // R5
  end

  AST_POP_SERVED: assert property (@(posedge clk) disable iff (rst)
    pop_valid[0] && int'(pop_user[0]) < int'(NUM_USERS) && !q_empty[pop_user[0]]
    |=> pop_ack[0]); // R5
endmodule

// File: tb/mq_shared_fifo_bench.sv
`timescale 1ns/1ps
module mq_shared_fifo_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0]       pv = '0, rv = '0;
  logic [1:0][1:0]  pu = '0, ru = '0;
  logic [1:0][15:0] pd = '0;
  logic [1:0]       pa, ra, re;
  logic [1:0][15:0] rdat;
  logic [3:0]       emp, ful;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int got;

  always #2 clk = ~clk;

  mq_shared_fifo u_mq_shared_fifo (
    .clk(clk), .rst(rst),
    .push_valid(pv), .push_user(pu), .push_data(pd), .push_ack(pa),
    .pop_valid(rv), .pop_user(ru), .pop_ack(ra), .pop_err(re), .pop_data(rdat),
    .q_empty(emp), .q_full(ful));

  function automatic logic [15:0] tagd(input int u, input int s);
    return 16'((u << 12) | (s & 'hFFF));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, sample 1 ns after the rising edge.
  task automatic cyc(input logic [1:0] v, input logic [1:0][1:0] u, input logic [1:0][15:0] d,
                     input logic [1:0] qv, input logic [1:0][1:0] qu);
    @(negedge clk);
    pv = v; pu = u; pd = d; rv = qv; ru = qu;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst = 1'b1; pv = '0; rv = '0; pu = '0; ru = '0; pd = '0;
    repeat (2) @(posedge clk);
    #1;
    chk(emp == 4'hF, "R1 empty flags under reset", emp, 15);
    chk(ful == 4'h0, "R1 full flags under reset", ful, 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic fill(input int u, input int s0, output int cnt);
    int s = s0;
    cnt = 0;
    for (int k = 0; k < 400; k++) begin
      cyc(2'b11, {2'(u), 2'(u)}, {tagd(u, s + 1), tagd(u, s)}, 2'b00, '0);
      cnt += int'(pa[0]) + int'(pa[1]);
      s   += int'(pa[0]) + int'(pa[1]);
      if (pa == 2'b00) break;
    end
  endtask

  task automatic drain(input int u, input int s0, input int n, input string tag);
    int k = 0;
    while (k < n) begin
      bit two = (n - k >= 2);
      cyc(2'b00, '0, '0, two ? 2'b11 : 2'b01, {2'(u), 2'(u)});
      chk(ra[0] && rdat[0] == tagd(u, s0 + k), tag, rdat[0], tagd(u, s0 + k));
      if (two) chk(ra[1] && rdat[1] == tagd(u, s0 + k + 1), tag, rdat[1], tagd(u, s0 + k + 1));
      k += two ? 2 : 1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset;
    chk(emp == 4'hF, "R1 empty after reset", emp, 15);
    chk(ful == 4'h0, "R1 not full after reset", ful, 0);

    // One user takes the whole memory, then drains through both pop ports.
    fill(2, 0, got);
    chk(got == 256, "R3 single user capacity", got, 256);
    chk(ful[2] == 1'b1, "R6 full flag on exhausted pool", ful[2], 1);
    drain(2, 0, 256, "R2 order user2 dual pop");
    chk(emp[2] == 1'b1, "R11 queue empty after drain", emp[2], 1);

    // Pop from an empty queue.
    cyc(2'b00, '0, '0, 2'b01, {2'd0, 2'd2});
    chk(re[0] == 1'b1 && ra[0] == 1'b0, "R7 empty pop flagged", {re[0], ra[0]}, 2);
    chk(emp[2] == 1'b1, "R7 empty pop leaves queue empty", emp[2], 1);

    // One word per user, two pushes per cycle.
    cyc(2'b11, {2'd1, 2'd0}, {tagd(1, 0), tagd(0, 0)}, 2'b00, '0);
    chk(pa == 2'b11, "R5 dual push users 0 and 1", pa, 3);
    cyc(2'b11, {2'd3, 2'd2}, {tagd(3, 0), tagd(2, 0)}, 2'b00, '0);
    chk(pa == 2'b11, "R5 dual push users 2 and 3", pa, 3);
    chk(emp == 4'h0, "R5 flags follow pushes", emp, 0);
    fill(0, 1, got);
    chk(got == 207, "R4 chunk-granular allocation", got, 207);
    chk(ful == 4'b0001, "R6 only chunk-starved user full", ful, 1);
    cyc(2'b01, {2'd0, 2'd1}, {16'h0, tagd(1, 1)}, 2'b00, '0);
    chk(pa[0] == 1'b1, "R4 partial chunk still accepts", pa[0], 1);
    drain(0, 0, 208, "R2 order user0");
    cyc(2'b00, '0, '0, 2'b11, {2'd3, 2'd1});
    chk(ra == 2'b11 && rdat[0] == tagd(1, 0), "R2 independent queue user1", rdat[0], tagd(1, 0));
    chk(rdat[1] == tagd(3, 0), "R2 independent queue user3", rdat[1], tagd(3, 0));
    cyc(2'b00, '0, '0, 2'b11, {2'd2, 2'd1});
    chk(ra == 2'b11 && rdat[0] == tagd(1, 1), "R2 second word user1", rdat[0], tagd(1, 1));
    chk(rdat[1] == tagd(2, 0), "R2 word user2", rdat[1], tagd(2, 0));
    chk(emp == 4'hF, "R2 all queues drained", emp, 15);
    fill(0, 0, got);
    chk(got == 208, "R11 drained chunks returned, partial ones kept", got, 208);

    // Last free chunk contested by both push ports; deferred release.
    do_reset;
    got = 0;
    for (int k = 0; k < 120; k++) begin
      cyc(2'b11, {2'd0, 2'd0}, {tagd(0, 2 * k + 1), tagd(0, 2 * k)}, 2'b00, '0);
      got += int'(pa[0]) + int'(pa[1]);
    end
    chk(got == 240, "R5 dual push run", got, 240);
    cyc(2'b11, {2'd2, 2'd1}, {tagd(2, 0), tagd(1, 0)}, 2'b00, '0);
    chk(pa == 2'b01, "R8 port 0 wins last chunk", pa, 1);
    chk(ful[2] == 1'b1 && ful[1] == 1'b0, "R6 full only for starved user", ful, 4);
    drain(0, 0, 15, "R2 order before chunk end");
    cyc(2'b01, {2'd0, 2'd2}, {16'h0, tagd(2, 0)}, 2'b01, {2'd0, 2'd0});
    chk(ra[0] == 1'b1 && rdat[0] == tagd(0, 15), "R9 last entry of chunk", rdat[0], tagd(0, 15));
    chk(pa[0] == 1'b0, "R9 freed chunk not reused same cycle", pa[0], 0);
    cyc(2'b01, {2'd0, 2'd2}, {16'h0, tagd(2, 0)}, 2'b00, '0);
    chk(pa[0] == 1'b1, "R9 freed chunk usable next cycle", pa[0], 1);
    cyc(2'b00, '0, '0, 2'b01, {2'd0, 2'd2});
    chk(ra[0] == 1'b1 && rdat[0] == tagd(2, 0), "R9 data in reused chunk", rdat[0], tagd(2, 0));

    // Pops are handled before pushes in a cycle.
    do_reset;
    cyc(2'b01, {2'd0, 2'd3}, {16'h0, tagd(3, 5)}, 2'b01, {2'd0, 2'd3});
    chk(re[0] == 1'b1 && pa[0] == 1'b1, "R10 pop before push", {re[0], pa[0]}, 3);
    cyc(2'b00, '0, '0, 2'b01, {2'd0, 2'd3});
    chk(ra[0] == 1'b1 && rdat[0] == tagd(3, 5), "R10 pushed word next cycle", rdat[0], tagd(3, 5));
    cyc(2'b00, '0, '0, 2'b00, '0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule